// File: doc/BRIEF.md
# Modulo-24 BCD Down Counter

This block is a synchronous two-digit decimal counter that runs downward through 23, 22, ..., 01, 00 and then wraps back to 23. It suits hour-of-day countdowns and similar timers whose range is not a power of ten. The count is held as two BCD digits, tens and units. Each digit lives in its own instance of a generic 4-bit binary up/down cell. That cell has a parallel load, a count enable, a direction select, a terminal-count flag and an asynchronous clear.

A small control stage joins the two cells. The units cell always counts down while enable is high. Its terminal-count flag marks the borrow: the units cell reloads 9 and the tens cell steps down by one. When both digits are zero, the tens terminal-count flag selects a reload of 2 and 3 instead, so 00 is followed by 23. The block carries no data stream, so it has no valid/ready handshake. Enable, clear and terminal count are plain level signals, and the counter can never stall the logic that drives it.

Top module: `bcd_mod24_down`

## Requirements
- R1: While `clr` is high, both digits read 0 at once, without waiting for a clock edge. The counter then starts from 00.
- R2: On a rising clock edge with `en` low, neither digit changes.
- R3: On a rising edge with `en` high and a nonzero units digit, the units digit drops by 1 and the tens digit holds.
- R4: On a rising edge with `en` high, units 0 and tens nonzero, the units digit becomes 9 and the tens digit drops by 1.
- R5: On a rising edge with `en` high and the count at 00, the count becomes 23 (tens 2, units 3).
- R6: `tc` is combinational. It is 1 exactly when `en` is 1 and both digits are 0.
- R7: Each digit is a 4-bit binary-coded value with the MSB first. The count always stays within 00..23: tens is at most 2, units is at most 9, and units is at most 3 when tens is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous active-high clear to 00 |
| en | input | 1 | Count enable, active high |
| tens | output | 4 | Tens digit, BCD |
| units | output | 4 | Units digit, BCD |
| tc | output | 1 | Terminal count: enabled and at 00 |

## Verification
A wrong borrow or wrap shows on the digit ports one clock edge after the enabled edge that caused it. Examples are a tens step without a units reload, a reload of 9 at 00, or a missed reload of 23. After that the count departs permanently from a reference sequence that cycles every 24 enabled edges. A fault in the terminal-count path shows on `tc` in the same cycle that enable is applied at 00. A broken clear shows on the digits within the same cycle, before any edge. Long enabled runs cover every borrow and the wrap more than once, and random gaps in enable expose any drift while the count is held.

// File: rtl/bcd24_pkg.sv
package bcd24_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/updn_cell.sv
module updn_cell #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         ce,
  input  logic         up,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ALL_ONE  = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = '0;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)     q <= ALL_ZERO;
    else if (ld) q <= din;
    else if (ce) q <= up ? q + 1'b1 : q - 1'b1;
  end

  // terminal value depends on direction
  assign tc = ce & (up ? (q == ALL_ONE) : (q == ALL_ZERO));

  // R1: clear forces the cell to zero
  AST_CELL_CLR_ZERO: assert property (@(posedge clk) clr |-> q == ALL_ZERO) else $error("cell clear"); // R1
  // load wins over counting
  AST_CELL_LD_FIRST: assert property (@(posedge clk) disable iff (clr) ld |=> q == $past(din)) else $error("cell load"); // R4
endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import bcd24_pkg::*;
#(
  parameter int TENS_WRAP  = 2,
  parameter int UNITS_WRAP = 3,
  parameter int UNITS_TOP  = 9
) (
  input  logic   en,
  input  logic   u_tc,
  input  logic   t_tc,
  output logic   u_ce,
  output logic   u_ld,
  output digit_t u_din,
  output logic   t_ce,
  output logic   t_ld,
  output digit_t t_din,
  output logic   wrap_tc
);
  localparam digit_t T_WRAP = digit_t'(TENS_WRAP);
  localparam digit_t U_WRAP = digit_t'(UNITS_WRAP);
  localparam digit_t U_TOP  = digit_t'(UNITS_TOP);

  assign u_ce    = en;
  assign u_ld    = u_tc;                       // units borrow: reload
  assign u_din   = t_tc ? U_WRAP : U_TOP;      // at 00 reload low digit of wrap
  assign t_ce    = u_tc;                       // tens steps on units borrow only
  assign t_ld    = t_tc;                       // tens at zero with borrow: wrap
  assign t_din   = T_WRAP;
  assign wrap_tc = t_tc;
endmodule

// File: rtl/bcd_mod24_down.sv
module bcd_mod24_down
  import bcd24_pkg::*;
#(
  parameter int TENS_WRAP  = 2,
  parameter int UNITS_WRAP = 3,
  parameter int UNITS_TOP  = 9
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               en,
  output logic [DIGIT_W-1:0] tens,
  output logic [DIGIT_W-1:0] units,
  output logic               tc
);
  localparam digit_t T_WRAP = digit_t'(TENS_WRAP);
  localparam digit_t U_WRAP = digit_t'(UNITS_WRAP);
  localparam digit_t U_TOP  = digit_t'(UNITS_TOP);

  logic   u_ce, u_ld, u_tc, t_ce, t_ld, t_tc;
  digit_t u_din, t_din;

  wrap_ctrl #(.TENS_WRAP(TENS_WRAP), .UNITS_WRAP(UNITS_WRAP), .UNITS_TOP(UNITS_TOP)) u_ctrl (
    .en(en), .u_tc(u_tc), .t_tc(t_tc),
    .u_ce(u_ce), .u_ld(u_ld), .u_din(u_din),
    .t_ce(t_ce), .t_ld(t_ld), .t_din(t_din),
    .wrap_tc(tc)
  );

  updn_cell #(.W(DIGIT_W)) u_units (
    .clk(clk), .clr(clr), .ld(u_ld), .ce(u_ce), .up(1'b0),
    .din(u_din), .q(units), .tc(u_tc)
  );

  updn_cell #(.W(DIGIT_W)) u_tens (
    .clk(clk), .clr(clr), .ld(t_ld), .ce(t_ce), .up(1'b0),
    .din(t_din), .q(tens), .tc(t_tc)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(tens) && $stable(units)) else $error("hold"); // R2
  AST_UNITS_STEP: assert property (@(posedge clk) disable iff (clr)
    en && units != 0 |=> units == $past(units) - 1'b1 && $stable(tens)) else $error("step"); // R3
  AST_BORROW: assert property (@(posedge clk) disable iff (clr)
    en && units == 0 && tens != 0 |=> units == U_TOP && tens == $past(tens) - 1'b1) else $error("borrow"); // R4
  AST_WRAP_23: assert property (@(posedge clk) disable iff (clr)
    en && units == 0 && tens == 0 |=> tens == T_WRAP && units == U_WRAP) else $error("wrap"); // R5
  AST_TC_ZERO: assert property (@(posedge clk) disable iff (clr)
    tc == (en && tens == 0 && units == 0)) else $error("tc"); // R6
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (clr)
    tens <= T_WRAP && units <= U_TOP && (tens != T_WRAP || units <= U_WRAP)) else $error("range"); // R7
endmodule

// File: tb/bcd_mod24_down_bench.sv
module bcd_mod24_down_bench;
  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en  = 1'b0;
  logic [3:0] tens, units;
  logic tc;
  int checks = 0, failures = 0;
  int model = 0;
  bit done = 1'b0;

  bcd_mod24_down u_bcd_mod24_down (.clk(clk), .clr(clr), .en(en), .tens(tens), .units(units), .tc(tc));

  always #2 clk = ~clk;

  function automatic int next_count(int s, bit e);
    if (!e) return s;
    return (s == 0) ? 23 : s - 1;
  endfunction

  function automatic string req_of(int s, bit e);
    if (!e) return "R2";
    if (s == 0) return "R5";
    if (s % 10 == 0) return "R4";
    return "R3";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit e);
    string r;
    en = e;
    #1;
    check("R6", tc, (e && model == 0) ? 1 : 0);
    r = req_of(model, e);
    @(posedge clk);
    model = next_count(model, e);
    #1;
    check(r, tens * 10 + units, model);
    check("R7", (tens <= 2 && units <= 9 && (tens != 2 || units <= 3)) ? 1 : 0, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    #1;
    check("R1", tens * 10 + units, 0);
    @(posedge clk); #1;
    clr = 1'b0;
    model = 0;
    // R5 directed: 00 wraps to 23, then a full R3/R4 run, twice
    for (int i = 0; i < 50; i++) step(1'b1);
    // R2 directed: hold with enable low
    for (int i = 0; i < 4; i++) step(1'b0);
    // random enable pattern
    for (int i = 0; i < 400; i++) step(($urandom % 4) != 0);
    // R1: clear mid-cycle with no edge
    en = 1'b1;
    @(negedge clk);
    clr = 1'b1;
    #0.5;
    check("R1", tens * 10 + units, 0);
    @(posedge clk); #1;
    check("R1", tens * 10 + units, 0);
    clr = 1'b0;
    model = 0;
    for (int i = 0; i < 30; i++) step(($urandom % 3) != 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule